// File: doc/BRIEF.md
# Region-Tagged Translation Buffer with Per-Entry Page Size

This block is a small, fully associative translation buffer. It maps 64-bit logical addresses to 50-bit physical addresses. The three highest address bits choose one of eight region registers, which software writes. The chosen register supplies a region identifier, and that identifier is part of every tag comparison. Each entry stores its own page size, given as a page shift. Only the address bits above that entry's page offset take part in the match. The offset bits pass through to the physical address unchanged.

Software fills and removes entries through the insert and purge ports. A lookup request gets its response one cycle later. The response is either a hit carrying the physical address, or a miss carrying a fixed vector code. The vector code lets a software handler walk its own page table and then issue an insert. Region registers can be rewritten at any time, for example on a context switch. A rewrite changes which entries can hit, and the buffer does not need to be flushed.

Top module: `region_tlb`

## Requirements
- R1: After a synchronous reset, every entry is invalid, and `rsp_valid` and `ins_reject` are low. A lookup made right after reset reports a miss.
- R2: The region identifier used for a tag comes from the region register selected by address bits 63:61. Rewriting that register makes the entries inserted under the old identifier unreachable. Restoring the old value makes them hit again, with no flush in between.
- R3: The legal page shifts on `ins_shift` are 12, 13, 14, 16, 18, 20, 22, 24, 26 and 28. These are the pages from 4K to 256M. An insert with any other shift writes nothing, and `ins_reject` is high in the cycle after the insert.
- R4: On a hit, `rsp_paddr` holds the entry's physical page bits above its page shift. The bits below the page shift are copied from the logical address.
- R5: `rsp_valid` is high exactly one cycle after a cycle with `lk_valid` high. Whenever it is high, exactly one of `rsp_hit` and `rsp_miss` is high.
- R6: A lookup with no matching entry sets `rsp_miss`, drives `rsp_vector` to the `MISS_VEC` parameter (default 8'h2A), and keeps `rsp_hit` low.
- R7: An insert that overlaps a valid entry with the same region identifier replaces that entry. At most one entry ever matches a lookup.
- R8: A purge invalidates every entry whose region identifier matches and whose page overlaps the purge address at the purge shift. Overlap is judged at the larger of the two page sizes. Other entries keep translating.
- R9: A new insert goes to the lowest-numbered invalid entry. When every entry is valid, it evicts a victim chosen by a round-robin pointer. The pointer starts at entry 0 after reset and advances only on such an eviction.
- R10: Two region registers that hold the same identifier reach the same entries, so an address in either region hits a shared page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rr_we | input | 1 | Region register write enable |
| rr_sel | input | 3 | Region register being written |
| rr_rid | input | RID_W | Region identifier to write |
| ins_valid | input | 1 | Insert command |
| ins_vaddr | input | 64 | Logical address of the inserted page |
| ins_paddr | input | 50 | Physical base address of the inserted page |
| ins_shift | input | 5 | Page shift (log2 of the page size) of the insert |
| pg_valid | input | 1 | Purge command |
| pg_vaddr | input | 64 | Logical address to purge |
| pg_shift | input | 5 | Page shift of the purge range |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 64 | Logical address to translate |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | No translation found |
| rsp_paddr | output | 50 | Translated physical address |
| rsp_vector | output | 8 | Miss vector code; zero on a hit |
| ins_reject | output | 1 | The previous cycle's insert had an illegal page shift |

## Verification
The assertions assume three things about the inputs:
- Reset is held high from time zero through the first clock edges.
- Insert and purge commands are never issued in the same cycle.
- The insert address and physical base are aligned to the page size being inserted.

The stimulus keeps to these assumptions:
- It drives every command on the falling edge, one command at a time.
- It samples the registered outputs one falling edge later.
- Every physical base it inserts is a multiple of the page size it inserts.

Under those conditions, the single-hit property depends only on how the block replaces overlapping entries.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W   = 64;
  localparam int PA_W   = 50;
  localparam int VRN_W  = 3;
  localparam int OFS_W  = VA_W - VRN_W;
  localparam int SHF_W  = 5;

  typedef logic [OFS_W-1:0] reg_ofs_t;
  typedef logic [PA_W-1:0]  paddr_t;
  typedef logic [SHF_W-1:0] pshift_t;

  function automatic logic shift_legal(pshift_t s);
    case (s)
      5'd12, 5'd13, 5'd14, 5'd16, 5'd18,
      5'd20, 5'd22, 5'd24, 5'd26, 5'd28: return 1'b1;
      default:                           return 1'b0;
    endcase
  endfunction

  // bits at and above the page shift are ones
  function automatic reg_ofs_t page_mask(pshift_t s);
    return ~((reg_ofs_t'(1) << s) - reg_ofs_t'(1));
  endfunction

  function automatic pshift_t wider(pshift_t a, pshift_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/tlb_region_file.sv
module tlb_region_file
  import tlb_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int RID_W = 24,
  parameter int NRD   = 3,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [RID_W-1:0] wr_rid,
  input  logic [IDX_W-1:0] rd_idx [NRD],
  output logic [RID_W-1:0] rd_rid [NRD]
);
  logic [RID_W-1:0] rid_q [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rid_q[i] <= '0;
    end else if (we) begin
      rid_q[wr_idx] <= wr_rid;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_rid[p] = rid_q[rd_idx[p]];
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     valid_i,
  input  logic             advance,
  output logic [IDX_W-1:0] victim_idx,
  output logic             has_free
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
    victim_idx = has_free ? free_idx : ptr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (advance) ptr_q <= (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
  end
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_pkg::*;
#(
  parameter int N     = 8,
  parameter int RID_W = 24,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  // lookup compare
  input  logic [RID_W-1:0] lk_rid,
  input  logic [VA_W-1:0]  lk_vaddr,
  output logic [N-1:0]     lk_hit,
  output paddr_t           lk_pa,
  // insert overlap compare
  input  logic [RID_W-1:0] in_rid,
  input  reg_ofs_t         in_vofs,
  input  pshift_t          in_shift,
  output logic [N-1:0]     in_ovl,
  // purge overlap compare
  input  logic [RID_W-1:0] pg_rid,
  input  reg_ofs_t         pg_vofs,
  input  pshift_t          pg_shift,
  output logic [N-1:0]     pg_ovl,
  // update
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  paddr_t           wr_pa,
  input  logic [N-1:0]     clr,
  output logic [N-1:0]     valid_o
);
  logic [N-1:0]     e_valid;
  logic [RID_W-1:0] e_rid   [N];
  reg_ofs_t         e_vofs  [N];
  paddr_t           e_pa    [N];
  pshift_t          e_shift [N];
  paddr_t           pa_each [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      e_valid <= '0;
    end else begin
      for (int i = 0; i < N; i++)
        e_valid[i] <= (e_valid[i] & ~clr[i]) | (wr_en && (wr_idx == IDX_W'(i)));
    end
  end

  // payload has no reset: only valid bits matter
  always_ff @(posedge clk) begin
    if (wr_en) begin
      e_rid[wr_idx]   <= in_rid;
      e_vofs[wr_idx]  <= in_vofs & page_mask(in_shift);
      e_pa[wr_idx]    <= wr_pa & page_mask(in_shift)[PA_W-1:0];
      e_shift[wr_idx] <= in_shift;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_ent
    reg_ofs_t own_m, in_m, pg_m;
    assign own_m = page_mask(e_shift[i]);
    assign in_m  = page_mask(wider(e_shift[i], in_shift));
    assign pg_m  = page_mask(wider(e_shift[i], pg_shift));

    assign lk_hit[i] = e_valid[i] && (e_rid[i] == lk_rid) &&
                       (((lk_vaddr[OFS_W-1:0] ^ e_vofs[i]) & own_m) == '0);
    assign in_ovl[i] = e_valid[i] && (e_rid[i] == in_rid) &&
                       (((in_vofs ^ e_vofs[i]) & in_m) == '0);
    assign pg_ovl[i] = e_valid[i] && (e_rid[i] == pg_rid) &&
                       (((pg_vofs ^ e_vofs[i]) & pg_m) == '0);
    assign pa_each[i] = (e_pa[i] & own_m[PA_W-1:0]) |
                        (lk_vaddr[PA_W-1:0] & ~own_m[PA_W-1:0]);
  end

  always_comb begin
    lk_pa = '0;
    for (int i = 0; i < N; i++)
      if (lk_hit[i]) lk_pa = lk_pa | pa_each[i];
  end

  assign valid_o = e_valid;
endmodule

// File: rtl/region_tlb.sv
module region_tlb
  import tlb_pkg::*;
#(
  parameter int         RID_W    = 24,
  parameter int         ENTRIES  = 8,
  parameter logic [7:0] MISS_VEC = 8'h2A
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rr_we,
  input  logic [2:0]       rr_sel,
  input  logic [RID_W-1:0] rr_rid,
  input  logic             ins_valid,
  input  logic [63:0]      ins_vaddr,
  input  logic [49:0]      ins_paddr,
  input  logic [4:0]       ins_shift,
  input  logic             pg_valid,
  input  logic [63:0]      pg_vaddr,
  input  logic [4:0]       pg_shift,
  input  logic             lk_valid,
  input  logic [63:0]      lk_vaddr,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic [49:0]      rsp_paddr,
  output logic [7:0]       rsp_vector,
  output logic             ins_reject
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int NREG  = 1 << VRN_W;

  logic [VRN_W-1:0] rd_idx [3];
  logic [RID_W-1:0] rd_rid [3];

  assign rd_idx[0] = lk_vaddr[VA_W-1 -: VRN_W];
  assign rd_idx[1] = ins_vaddr[VA_W-1 -: VRN_W];
  assign rd_idx[2] = pg_vaddr[VA_W-1 -: VRN_W];

  tlb_region_file #(.NREG(NREG), .RID_W(RID_W), .NRD(3)) u_rr (
    .clk(clk), .rst(rst), .we(rr_we), .wr_idx(rr_sel), .wr_rid(rr_rid),
    .rd_idx(rd_idx), .rd_rid(rd_rid)
  );

  logic [ENTRIES-1:0] lk_hit, in_ovl, pg_ovl, valid_v, clr;
  paddr_t             lk_pa;
  logic               ins_ok, ovl_any, has_free, wr_en, advance;
  logic [IDX_W-1:0]   first_ovl, victim_idx, wr_idx;

  assign ins_ok  = ins_valid && shift_legal(ins_shift);
  assign ovl_any = |in_ovl;

  always_comb begin
    first_ovl = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (in_ovl[i]) first_ovl = IDX_W'(i);
  end

  // an overlapped entry is reused in place; others overlapped are dropped
  assign wr_en   = ins_ok;
  assign wr_idx  = ovl_any ? first_ovl : victim_idx;
  assign advance = ins_ok && !ovl_any && !has_free;
  assign clr     = (pg_valid ? pg_ovl : '0) | (ins_ok ? in_ovl : '0);

  tlb_victim #(.N(ENTRIES)) u_vic (
    .clk(clk), .rst(rst), .valid_i(valid_v), .advance(advance),
    .victim_idx(victim_idx), .has_free(has_free)
  );

  tlb_entry_array #(.N(ENTRIES), .RID_W(RID_W)) u_arr (
    .clk(clk), .rst(rst),
    .lk_rid(rd_rid[0]), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_pa(lk_pa),
    .in_rid(rd_rid[1]), .in_vofs(ins_vaddr[OFS_W-1:0]), .in_shift(ins_shift), .in_ovl(in_ovl),
    .pg_rid(rd_rid[2]), .pg_vofs(pg_vaddr[OFS_W-1:0]), .pg_shift(pg_shift), .pg_ovl(pg_ovl),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_pa(ins_paddr), .clr(clr), .valid_o(valid_v)
  );

  logic any_hit;
  assign any_hit = |lk_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_miss   <= 1'b0;
      rsp_paddr  <= '0;
      rsp_vector <= '0;
      ins_reject <= 1'b0;
    end else begin
      rsp_valid  <= lk_valid;
      rsp_hit    <= lk_valid && any_hit;
      rsp_miss   <= lk_valid && !any_hit;
      rsp_paddr  <= (lk_valid && any_hit) ? lk_pa : '0;
      rsp_vector <= (lk_valid && !any_hit) ? MISS_VEC : 8'h00;
      ins_reject <= ins_valid && !shift_legal(ins_shift);
    end
  end
endmodule

// File: rtl/region_tlb_chk.sv
module region_tlb_chk #(
  parameter int         N        = 8,
  parameter logic [7:0] MISS_VEC = 8'h2A
) (
  input logic         clk,
  input logic         rst,
  input logic         lk_valid,
  input logic [63:0]  lk_vaddr,
  input logic         ins_valid,
  input logic         rsp_valid,
  input logic         rsp_hit,
  input logic         rsp_miss,
  input logic [49:0]  rsp_paddr,
  input logic [7:0]   rsp_vector,
  input logic         ins_reject,
  input logic [N-1:0] hit_vec
);
  // R5
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    $past(lk_valid) |-> rsp_valid);
  // R5
  rsp_no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(lk_valid) |-> !rsp_valid && !rsp_hit && !rsp_miss);
  // R5
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_hit != rsp_miss));
  // R6
  miss_vector_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_miss |-> (rsp_vector == MISS_VEC) && !rsp_hit);
  // R7
  single_hit_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
  // R4
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_paddr[11:0] == $past(lk_vaddr[11:0]));
  // R3
  reject_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ins_reject |-> $past(ins_valid));
endmodule

bind region_tlb region_tlb_chk #(.N(ENTRIES), .MISS_VEC(MISS_VEC)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .ins_valid(ins_valid), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_miss(rsp_miss), .rsp_paddr(rsp_paddr), .rsp_vector(rsp_vector),
  .ins_reject(ins_reject), .hit_vec(lk_hit)
);

// File: tb/region_tlb_bench.sv
module region_tlb_bench;
  localparam int         CLK_PERIOD = 10;
  localparam int         RID_W      = 24;
  localparam logic [7:0] MISS_VEC   = 8'h2A;
  localparam int         WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rr_we = 0;
  logic [2:0]  rr_sel = 0;
  logic [RID_W-1:0] rr_rid = 0;
  logic        ins_valid = 0;
  logic [63:0] ins_vaddr = 0;
  logic [49:0] ins_paddr = 0;
  logic [4:0]  ins_shift = 0;
  logic        pg_valid = 0;
  logic [63:0] pg_vaddr = 0;
  logic [4:0]  pg_shift = 0;
  logic        lk_valid = 0;
  logic [63:0] lk_vaddr = 0;
  logic        rsp_valid, rsp_hit, rsp_miss, ins_reject;
  logic [49:0] rsp_paddr;
  logic [7:0]  rsp_vector;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  region_tlb #(.RID_W(RID_W), .ENTRIES(8), .MISS_VEC(MISS_VEC)) u_region_tlb (
    .clk(clk), .rst(rst), .rr_we(rr_we), .rr_sel(rr_sel), .rr_rid(rr_rid),
    .ins_valid(ins_valid), .ins_vaddr(ins_vaddr), .ins_paddr(ins_paddr), .ins_shift(ins_shift),
    .pg_valid(pg_valid), .pg_vaddr(pg_vaddr), .pg_shift(pg_shift),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_paddr(rsp_paddr), .rsp_vector(rsp_vector), .ins_reject(ins_reject)
  );

  // {vaddr, expect_hit, expect_paddr}
  localparam int NT = 6;
  localparam logic [114:0] LK_TAB [NT] = '{
    {64'h0000_0000_0040_0ABC, 1'b1, 50'h0_1234_5ABC},  // R4 4K page
    {64'h2000_0000_1ABC_DEF0, 1'b1, 50'h3_0ABC_DEF0},  // R4 256M page
    {64'h6000_0000_0001_1234, 1'b1, 50'h0_00AB_1234},  // R4 64K page
    {64'h6000_0000_0002_0000, 1'b0, 50'h0},            // R6 next 64K page
    {64'h4000_0000_0040_0123, 1'b1, 50'h0_1234_5123},  // R10 shared rid
    {64'h0000_0000_0041_0000, 1'b0, 50'h0}             // R6 unmapped
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr_rr(input logic [2:0] idx, input logic [RID_W-1:0] rid);
    @(negedge clk); rr_we = 1; rr_sel = idx; rr_rid = rid;
    @(negedge clk); rr_we = 0;
  endtask

  task automatic do_insert(input logic [63:0] va, input logic [49:0] pa,
                           input logic [4:0] sh, output logic rej);
    @(negedge clk); ins_valid = 1; ins_vaddr = va; ins_paddr = pa; ins_shift = sh;
    @(negedge clk); ins_valid = 0; rej = ins_reject;
  endtask

  task automatic do_purge(input logic [63:0] va, input logic [4:0] sh);
    @(negedge clk); pg_valid = 1; pg_vaddr = va; pg_shift = sh;
    @(negedge clk); pg_valid = 0;
  endtask

  task automatic do_lookup(input logic [63:0] va, output logic hit, output logic miss,
                           output logic [49:0] pa, output logic [7:0] vec, output logic vld);
    @(negedge clk); lk_valid = 1; lk_vaddr = va;
    @(negedge clk); lk_valid = 0;
    hit = rsp_hit; miss = rsp_miss; pa = rsp_paddr; vec = rsp_vector; vld = rsp_valid;
  endtask

  task automatic expect_hit(input logic [63:0] va, input logic [49:0] exp, input string req);
    logic h, m, v; logic [49:0] p; logic [7:0] vc;
    do_lookup(va, h, m, p, vc, v);
    chk(h && !m && v, req, {63'd0, h}, 64'd1);
    chk(p == exp, req, {14'd0, p}, {14'd0, exp});
  endtask

  task automatic expect_miss(input logic [63:0] va, input string req);
    logic h, m, v; logic [49:0] p; logic [7:0] vc;
    do_lookup(va, h, m, p, vc, v);
    chk(m && !h && v, req, {63'd0, m}, 64'd1);
    chk(vc == MISS_VEC, req, {56'd0, vc}, {56'd0, MISS_VEC});
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    logic rej;
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk(!rsp_valid && !ins_reject, "R1", {62'd0, rsp_valid, ins_reject}, 64'd0);
    expect_miss(64'h0000_0000_0040_0ABC, "R1");

    wr_rr(3'd0, 24'h000100);
    wr_rr(3'd1, 24'h000200);
    wr_rr(3'd2, 24'h000100);
    wr_rr(3'd3, 24'h000303);

    do_insert(64'h0000_0000_0040_0000, 50'h0_1234_5000, 5'd12, rej);
    chk(!rej, "R3", {63'd0, rej}, 64'd0);
    do_insert(64'h2000_0000_1000_0000, 50'h3_0000_0000, 5'd28, rej);
    chk(!rej, "R3", {63'd0, rej}, 64'd0);
    do_insert(64'h6000_0000_0001_0000, 50'h0_00AB_0000, 5'd16, rej);
    chk(!rej, "R3", {63'd0, rej}, 64'd0);

    for (int k = 0; k < NT; k++) begin
      if (LK_TAB[k][50]) expect_hit(LK_TAB[k][114:51], LK_TAB[k][49:0], "R4/R10 table");
      else               expect_miss(LK_TAB[k][114:51], "R6 table");
    end

    // R3 illegal shifts are rejected and write nothing
    do_insert(64'h0000_0000_0090_0000, 50'h0_0777_0000, 5'd15, rej);
    chk(rej, "R3", {63'd0, rej}, 64'd1);
    expect_miss(64'h0000_0000_0090_0000, "R3");
    do_insert(64'h0000_0000_0090_0000, 50'h0_0777_0000, 5'd11, rej);
    chk(rej, "R3", {63'd0, rej}, 64'd1);
    expect_miss(64'h0000_0000_0090_0400, "R3");

    // R2 region register rewrite hides and restores entries
    wr_rr(3'd3, 24'h000777);
    expect_miss(64'h6000_0000_0001_1234, "R2");
    wr_rr(3'd3, 24'h000303);
    expect_hit(64'h6000_0000_0001_1234, 50'h0_00AB_1234, "R2");

    // R7 overlapping insert replaces
    do_insert(64'h0000_0000_0040_0000, 50'h0_5550_0000, 5'd13, rej);
    expect_hit(64'h0000_0000_0040_0ABC, 50'h0_5550_0ABC, "R7");
    expect_hit(64'h0000_0000_0040_1004, 50'h0_5550_1004, "R7");

    // R8 purge through shared region at smaller size
    do_purge(64'h4000_0000_0040_1000, 5'd12);
    expect_miss(64'h0000_0000_0040_0ABC, "R8");
    expect_hit(64'h2000_0000_1ABC_DEF0, 50'h3_0ABC_DEF0, "R8");

    // R9 allocation order and round robin
    do_reset();
    for (int i = 0; i < 8; i++)
      do_insert(64'(i) << 12, 50'(32'h100 + i) << 12, 5'd12, rej);
    expect_hit(64'h7000, 50'h107000, "R9");
    do_insert(64'h8000, 50'h108000, 5'd12, rej);
    expect_miss(64'h0000, "R9");
    expect_hit(64'h1000, 50'h101000, "R9");
    expect_hit(64'h8000, 50'h108000, "R9");
    do_insert(64'h9000, 50'h109000, 5'd12, rej);
    expect_miss(64'h1000, "R9");
    expect_hit(64'h2000, 50'h102000, "R9");

    finish_run();
  end
endmodule